// File: doc/BRIEF.md
# Scaled Pointer Address Generator

This unit forms the shared-memory address for load and store instructions. Every access carries a 9-bit address field and an access size. The top bit of the field picks between two forms. The first is a plain absolute address taken from the low eight bits. The second is a pointer-relative access through one of two pointer registers. In a pointer-relative access, a signed 5-bit offset is multiplied by the access size in bytes. It is then either added to the pointer without changing it, applied to the pointer before the access, or applied to the pointer after the access.

Both pointers are loaded with one common start value when the core starts (`startLoad`). The effective address is produced in the same cycle as the access strobe. The pointer write-back lands on the next clock edge. Increment and decrement are not separate modes: the sign of the offset chooses the direction. All pointer arithmetic wraps modulo 2^ADDR_W. The memory and its arbitration sit outside this unit.

Top module: `scaled_ptr_agu`

## Requirements
- R1: After reset both pointer outputs read zero.
- R2: When `startLoad` is high at a clock edge, both pointers take `startVal` on that edge. This load wins over any pointer update requested in the same cycle. The address for that cycle is still formed from the old pointers.
- R3: With field bit 8 at 0, `effAddr` equals field bits 7..0 zero-extended, and neither pointer changes.
- R4: With field bit 8 at 1, bit 7 selects pointer A (0) or B (1), bits 6..5 give the mode, and bits 4..0 are a two's-complement offset from -16 to +15. The pointer that is not selected never changes.
- R5: The offset is scaled by the access size: `accSize` 00 = byte ×1, 01 = word ×2, 10 = long ×4, 11 = quad ×16.
- R6: Mode 00 (indexed) and mode 11 (reserved, handled as indexed) give `effAddr` = pointer + scaled offset and leave the pointer unchanged.
- R7: Mode 01 (pre-update) gives `effAddr` = pointer + scaled offset, and the pointer holds that same value after the edge.
- R8: Mode 10 (post-update) gives `effAddr` = the current pointer, and the pointer becomes pointer + scaled offset after the edge.
- R9: Pointer and address arithmetic wraps modulo 2^ADDR_W in both directions.
- R10: `effAddr` is combinational from the field in the strobe cycle. While `accStrobe` is low, the pointers do not change unless a load is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startLoad | input | 1 | Core start: load both pointers with `startVal` |
| startVal | input | ADDR_W | Common start value for the pointers |
| accStrobe | input | 1 | An access is issued this cycle |
| addrField | input | 9 | Address field of the access instruction |
| accSize | input | 2 | Access size code (byte, word, long, quad) |
| effAddr | output | ADDR_W | Effective byte address of the access |
| ptrA | output | ADDR_W | Current value of pointer A |
| ptrB | output | ADDR_W | Current value of pointer B |

## Verification
The properties check several rules on every cycle. A start load lands the start value in both pointers. Absolute and indexed accesses leave the pointers alone. The pointer that is not selected holds its value. Idle cycles change nothing. A post-update access presents the unmodified pointer, and after a pre-update access the pointer equals the address that was presented. The scaled arithmetic itself can only be shown by the bench's scenarios: the four size multipliers, negative offsets, the reserved mode acting as indexed, the load overriding an update in the same cycle, and wrap-around at both ends of the address space. Each scenario is compared against a model of the encoding.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;
  localparam int FIELD_W = 9;
  localparam int ABS_W   = 8;
  localparam int OFS_W   = 5;
  localparam int NUM_PTR = 2;
  localparam int SEL_W   = $clog2(NUM_PTR);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_QUAD = 2'b11
  } accSizeT;

  typedef enum logic [1:0] {
    MODE_INDEX = 2'b00,
    MODE_PRE   = 2'b01,
    MODE_POST  = 2'b10,
    MODE_RSVD  = 2'b11
  } ptrModeT;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             useAbs;
    logic [SEL_W-1:0] ptrSel;
    logic             addrFromBase;
    logic             doUpdate;
  } aguCtrlT;

  function automatic logic [2:0] sizeShift(input accSizeT sz);
    case (sz)
      SZ_BYTE: return 3'd0;
      SZ_WORD: return 3'd1;
      SZ_LONG: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/agu_ctrl.sv
`timescale 1ns/1ps
module agu_ctrl
  import agu_pkg::*;
(
  input  logic    accStrobe,
  input  logic    startLoad,
  input  logic [3:0] fieldHi,   // field bits 8..5
  output aguCtrlT ctrl
);
  ptrModeT mode;
  logic    isPtr;

  assign mode  = ptrModeT'(fieldHi[1:0]);
  assign isPtr = fieldHi[3];

  always_comb begin
    ctrl              = '0;
    ctrl.load         = startLoad;
    ctrl.useAbs       = !isPtr;
    ctrl.ptrSel       = fieldHi[2];
    ctrl.addrFromBase = isPtr && (mode == MODE_POST);
    ctrl.doUpdate     = accStrobe && isPtr &&
                        ((mode == MODE_PRE) || (mode == MODE_POST));
  end
endmodule

// File: rtl/agu_ofs_scale.sv
`timescale 1ns/1ps
module agu_ofs_scale
  import agu_pkg::*;
#(
  parameter int ADDR_W = 20
)(
  input  logic [OFS_W-1:0]  ofs,
  input  logic [1:0]        accSize,
  output logic [ADDR_W-1:0] scaled
);
  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ext;
  assign ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};

  always_comb scaled = ext << sizeShift(accSizeT'(accSize));
endmodule

// File: rtl/agu_datapath.sv
`timescale 1ns/1ps
module agu_datapath
  import agu_pkg::*;
#(
  parameter int ADDR_W = 20
)(
  input  logic                            clk,
  input  logic                            rstN,
  input  aguCtrlT                         ctrl,
  input  logic [ADDR_W-1:0]               startVal,
  input  logic [ABS_W-1:0]                absField,
  input  logic [OFS_W-1:0]                ofsField,
  input  logic [1:0]                      accSize,
  output logic [ADDR_W-1:0]               effAddr,
  output logic [NUM_PTR-1:0][ADDR_W-1:0]  ptrVal
);
  localparam int PAD_W = ADDR_W - ABS_W;

  logic [ADDR_W-1:0] scaledOfs;
  logic [ADDR_W-1:0] basePtr;
  logic [ADDR_W-1:0] sumAddr;

  agu_ofs_scale #(.ADDR_W(ADDR_W)) i_scale (
    .ofs     (ofsField),
    .accSize (accSize),
    .scaled  (scaledOfs)
  );

  assign basePtr = ptrVal[ctrl.ptrSel];
  assign sumAddr = basePtr + scaledOfs;

  always_comb begin
    if (ctrl.useAbs)            effAddr = {{PAD_W{1'b0}}, absField};
    else if (ctrl.addrFromBase) effAddr = basePtr;
    else                        effAddr = sumAddr;
  end

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rstN)
        ptrVal[i] <= '0;
      else if (ctrl.load)
        ptrVal[i] <= startVal;
      else if (ctrl.doUpdate && (ctrl.ptrSel == SEL_W'(i)))
        ptrVal[i] <= sumAddr;
    end
  end
endmodule

// File: rtl/scaled_ptr_agu.sv
`timescale 1ns/1ps
module scaled_ptr_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W = 20
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startLoad,
  input  logic [ADDR_W-1:0]  startVal,
  input  logic               accStrobe,
  input  logic [8:0]         addrField,
  input  logic [1:0]         accSize,
  output logic [ADDR_W-1:0]  effAddr,
  output logic [ADDR_W-1:0]  ptrA,
  output logic [ADDR_W-1:0]  ptrB
);
  aguCtrlT ctrl;
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptrVal;

  agu_ctrl i_ctrl (
    .accStrobe (accStrobe),
    .startLoad (startLoad),
    .fieldHi   (addrField[8:5]),
    .ctrl      (ctrl)
  );

  agu_datapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .startVal (startVal),
    .absField (addrField[ABS_W-1:0]),
    .ofsField (addrField[OFS_W-1:0]),
    .accSize  (accSize),
    .effAddr  (effAddr),
    .ptrVal   (ptrVal)
  );

  assign ptrA = ptrVal[0];
  assign ptrB = ptrVal[1];
endmodule

// File: rtl/agu_checker.sv
`timescale 1ns/1ps
module agu_checker #(
  parameter int ADDR_W = 20
)(
  input logic              clk,
  input logic              rstN,
  input logic              startLoad,
  input logic [ADDR_W-1:0] startVal,
  input logic              accStrobe,
  input logic [8:0]        addrField,
  input logic [ADDR_W-1:0] effAddr,
  input logic [ADDR_W-1:0] ptrA,
  input logic [ADDR_W-1:0] ptrB
);
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    startLoad |=> (ptrA == $past(startVal)) && (ptrB == $past(startVal))); // R2

  AST_ABS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && !addrField[8]) |-> (effAddr == {{(ADDR_W-8){1'b0}}, addrField[7:0]})); // R3

  AST_ABS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && !addrField[8] && !startLoad) |=> ($stable(ptrA) && $stable(ptrB))); // R3

  AST_UNSEL_A_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && addrField[8] && addrField[7] && !startLoad) |=> $stable(ptrA)); // R4

  AST_UNSEL_B_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && addrField[8] && !addrField[7] && !startLoad) |=> $stable(ptrB)); // R4

  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && addrField[8] && (addrField[6] == addrField[5]) && !startLoad)
      |=> ($stable(ptrA) && $stable(ptrB))); // R6

  AST_PRE_FOLLOW_A: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && (addrField[8:5] == 4'b1001) && !startLoad) |=> (ptrA == $past(effAddr))); // R7

  AST_PRE_FOLLOW_B: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && (addrField[8:5] == 4'b1101) && !startLoad) |=> (ptrB == $past(effAddr))); // R7

  AST_POST_BASE_A: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && (addrField[8:5] == 4'b1010)) |-> (effAddr == ptrA)); // R8

  AST_POST_BASE_B: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && (addrField[8:5] == 4'b1110)) |-> (effAddr == ptrB)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!accStrobe && !startLoad) |=> ($stable(ptrA) && $stable(ptrB))); // R10
endmodule

bind scaled_ptr_agu agu_checker #(.ADDR_W(ADDR_W)) i_agu_checker (
  .clk       (clk),
  .rstN      (rstN),
  .startLoad (startLoad),
  .startVal  (startVal),
  .accStrobe (accStrobe),
  .addrField (addrField),
  .effAddr   (effAddr),
  .ptrA      (ptrA),
  .ptrB      (ptrB)
);

// File: tb/test_scaled_ptr_agu.sv
`timescale 1ns/1ps
module test_scaled_ptr_agu;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startLoad = 1'b0;
  logic [AW-1:0] startVal = '0;
  logic          accStrobe = 1'b0;
  logic [8:0]    addrField = '0;
  logic [1:0]    accSize = '0;
  logic [AW-1:0] effAddr, ptrA, ptrB;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  scaled_ptr_agu #(.ADDR_W(AW)) i_scaled_ptr_agu (
    .clk(clk), .rstN(rstN), .startLoad(startLoad), .startVal(startVal),
    .accStrobe(accStrobe), .addrField(addrField), .accSize(accSize),
    .effAddr(effAddr), .ptrA(ptrA), .ptrB(ptrB)
  );

  typedef struct {
    logic          chkEff;
    logic [AW-1:0] eff;
    logic [AW-1:0] a;
    logic [AW-1:0] b;
    string         tag;
  } expT;

  expT sb[$];
  logic [AW-1:0] mA = '0;
  logic [AW-1:0] mB = '0;

  task automatic chk(input string tag, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [8:0] pf(input logic sel, input logic [1:0] md, input int ofs);
    return {1'b1, sel, md, ofs[4:0]};
  endfunction

  // driver: model the requirements, push expectation, drive at negedge
  task automatic doOp(input logic ld, input logic [AW-1:0] sv, input logic stb,
                      input logic [8:0] fld, input logic [1:0] sz, input string tag);
    expT it;
    logic [AW-1:0] so, base, sum;
    logic upd;
    so = {{(AW-5){fld[4]}}, fld[4:0]};
    case (sz)
      2'd0: so = so;
      2'd1: so = so << 1;
      2'd2: so = so << 2;
      default: so = so << 4;
    endcase
    base = fld[7] ? mB : mA;
    sum  = base + so;
    upd  = 1'b0;
    if (!fld[8]) it.eff = AW'(fld[7:0]);
    else begin
      case (fld[6:5])
        2'b01: begin it.eff = sum;  upd = 1'b1; end
        2'b10: begin it.eff = base; upd = 1'b1; end
        default: it.eff = sum;
      endcase
    end
    it.chkEff = stb;
    if (ld) begin mA = sv; mB = sv; end
    else if (stb && fld[8] && upd) begin
      if (fld[7]) mB = sum; else mA = sum;
    end
    it.a = mA; it.b = mB; it.tag = tag;
    @(negedge clk);
    startLoad = ld; startVal = sv; accStrobe = stb; addrField = fld; accSize = sz;
    sb.push_back(it);
  endtask

  // monitor: address mid-cycle, pointers after the edge
  initial begin
    expT it;
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        if (it.chkEff) chk(it.tag, "effAddr", effAddr, it.eff);
        @(posedge clk);
        #1;
        chk(it.tag, "ptrA", ptrA, it.a);
        chk(it.tag, "ptrB", ptrB, it.b);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1", "ptrA reset", ptrA, '0);
    chk("R1", "ptrB reset", ptrB, '0);

    doOp(1, 20'h01000, 0, 9'h000, 2'd0, "R2 start load");
    doOp(0, '0, 1, 9'h0AB, 2'd2, "R3 absolute");
    doOp(0, '0, 1, 9'h0FF, 2'd3, "R3 absolute top");
    doOp(0, '0, 1, pf(0, 2'b00, 3), 2'd0, "R6 indexed A byte");
    doOp(0, '0, 1, pf(1, 2'b00, -1), 2'd2, "R5 indexed B long negative");
    doOp(0, '0, 1, pf(0, 2'b00, 1), 2'd1, "R5 word scale");
    doOp(0, '0, 1, pf(0, 2'b00, 1), 2'd3, "R5 quad scale");
    doOp(0, '0, 1, pf(0, 2'b01, 2), 2'd2, "R7 pre A long");
    doOp(0, '0, 1, pf(1, 2'b10, -6), 2'd2, "R8 post B long");
    doOp(0, '0, 1, pf(0, 2'b11, 5), 2'd0, "R6 reserved as indexed");
    doOp(0, '0, 1, pf(1, 2'b01, 15), 2'd3, "R4 pre B leaves A");
    doOp(0, '0, 0, pf(0, 2'b01, 7), 2'd2, "R10 idle no update");
    doOp(1, 20'h00040, 1, pf(0, 2'b01, 1), 2'd3, "R2 load beats update");
    doOp(0, '0, 1, pf(0, 2'b10, -16), 2'd3, "R9 wrap below zero");
    doOp(1, 20'hFFFF8, 0, 9'h000, 2'd0, "R2 reload");
    doOp(0, '0, 1, pf(0, 2'b01, 15), 2'd0, "R9 wrap above top");
    doOp(0, '0, 1, pf(1, 2'b10, -16), 2'd1, "R8 post B word");
    doOp(0, '0, 0, 9'h000, 2'd0, "R10 final idle");

    wait (sb.size() == 0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule